// File: doc/BRIEF.md
# Media Exception Status Unit

This unit holds the status state of a two-lane media pipeline in a wide-issue processor. It keeps a primary status word and a secondary status word. The primary word carries the exception cause code, the overflow flag and sticky bits of lane 0, an accumulated-overflow flag and a trap-enable bit. The secondary word carries only the overflow flag and sticky bits of lane 1. Each cycle the unit may see three things. A setup event announces a media instruction entering a lane, and it may clear that lane's overflow state. An exception event reports a cause code, the issuing lane and a set of sticky bits. A software load replaces one whole word.

A mode input picks between two behaviours. In the default mode, overflow status follows the issuing lane, and every overflow sets the accumulated flag. In the alternate mode, all overflow status goes to the primary word. If the trap-enable bit is also set, the overflow raises an interrupt request in the same cycle and the accumulated flag is left alone. The unit does not detect overflow and does not deliver interrupts.

Top module: `media_status_unit`

## Requirements
- R1: The cause field (primary word bits [2:0], code 0 meaning none, code 1 meaning overflow) takes the cause of an exception event only while it holds 0. Once it is non-zero, later events do not change it.
- R2: An exception event whose cause is not 1 changes only the cause field. It leaves the overflow flags (bit 3), the sticky bits (bits [7:4]) and the accumulated flag (bit 8) unchanged.
- R3: In the default mode (mode input 0), an overflow event from lane 1 sets the secondary word's overflow flag and ORs the event's sticky bits into the secondary word's bits [7:4].
- R4: An overflow event from lane 0, and every overflow event in the alternate mode, sets the primary word's overflow flag and ORs the sticky bits into the primary word's bits [7:4].
- R5: An overflow event sets the accumulated flag (primary bit 8) in the next cycle, whatever its lane. The one exception is the alternate mode with the trap-enable bit (primary bit 9) set, where the flag is not set.
- R6: trap_req is high in the same cycle as an overflow event only when the mode input is 1 and the stored trap-enable bit is 1. Otherwise it is low.
- R7: A setup event for lane 0 without the keep attribute clears the primary word's overflow flag and sticky bits.
- R8: A setup event for lane 1 without the keep attribute clears the secondary word's overflow flag and sticky bits. With the keep attribute, a setup event changes nothing.
- R9: When a setup clear and an overflow update target the same lane in the same cycle, the overflow update wins. The flag becomes 1 and the sticky bits become their old value ORed with the event's bits.
- R10: A software load (sel 0 = primary, 1 = secondary) replaces the selected word on the next edge and overrides any event update to that word in that cycle. The secondary word stores only bits 3 and [7:4]; its other bits read 0.
- R11: Reset clears every field of both words, and trap_req reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Media instruction setup event |
| setup_lane | input | 1 | Lane of the setup event |
| setup_keep | input | 1 | Keep-overflow attribute; suppresses the clear |
| exc_valid | input | 1 | Exception event |
| exc_cause | input | 3 | Cause code of the exception (1 = overflow) |
| exc_lane | input | 1 | Lane that raised the exception |
| exc_sticky | input | 4 | Sticky bits to accumulate on overflow |
| alt_mode | input | 1 | Selects the alternate behaviour |
| sw_wr_en | input | 1 | Software load strobe |
| sw_wr_sel | input | 1 | Word selected by the load |
| sw_wr_data | input | 10 | Value loaded |
| stat0_word | output | 10 | Primary status word |
| stat1_word | output | 10 | Secondary status word |
| trap_req | output | 1 | Immediate media-exception request |

## Verification
All stored state appears on the two status words one edge after the event that changes it. A wrong steering choice or a lost sticky bit is therefore visible in the very next cycle, as a flag set in the wrong word. A cause code that is overwritten shows as soon as a second event arrives after the first one. A bad trap-enable bit shows only through trap_req, in the same cycle as the next alternate-mode overflow. A bad trap-enable bit also hides an accumulated-flag update that should have happened.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

  localparam int CAUSE_W_DEF  = 3;
  localparam int STICKY_W_DEF = 4;
  localparam int CAUSE_OVF_CODE = 1;

  // lane whose status an overflow updates
  function automatic logic f_lane_pick(input logic alt, input logic lane);
    return alt ? 1'b0 : lane;
  endfunction

  // overflow becomes an immediate request instead of an accumulated flag
  function automatic logic f_trap_now(input logic alt, input logic trap_en);
    return alt & trap_en;
  endfunction

endpackage

// File: rtl/mstat_steer.sv
module mstat_steer #(
  parameter int CAUSE_W = mstat_pkg::CAUSE_W_DEF,
  parameter int LANES   = 2
) (
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_lane,
  input  logic               alt_mode,
  input  logic               trap_en,
  input  logic               setup_valid,
  input  logic               setup_lane,
  input  logic               setup_keep,
  output logic [LANES-1:0]   lane_set,
  output logic [LANES-1:0]   lane_clr,
  output logic               aovf_set,
  output logic               trap_fire,
  output logic               ev_ovf
);
  logic tgt;

  assign ev_ovf    = exc_valid && (exc_cause == CAUSE_W'(mstat_pkg::CAUSE_OVF_CODE));
  assign tgt       = mstat_pkg::f_lane_pick(alt_mode, exc_lane);
  assign trap_fire = ev_ovf && mstat_pkg::f_trap_now(alt_mode, trap_en);
  assign aovf_set  = ev_ovf && !trap_fire;

  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign lane_set[i] = ev_ovf && (tgt == 1'(i));
    assign lane_clr[i] = setup_valid && !setup_keep && (setup_lane == 1'(i));
  end
endmodule

// File: rtl/mstat_lane.sv
module mstat_lane #(
  parameter int STICKY_W = mstat_pkg::STICKY_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic                ld_ovf,
  input  logic [STICKY_W-1:0] ld_sticky,
  input  logic                set,
  input  logic                clr,
  input  logic [STICKY_W-1:0] sticky_in,
  output logic                ovf_q,
  output logic [STICKY_W-1:0] sticky_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      sticky_q <= '0;
    end else if (ld) begin
      ovf_q    <= ld_ovf;
      sticky_q <= ld_sticky;
    end else if (set) begin
      ovf_q    <= 1'b1;
      sticky_q <= sticky_q | sticky_in;
    end else if (clr) begin
      ovf_q    <= 1'b0;
      sticky_q <= '0;
    end
  end
endmodule

// File: rtl/mstat_head.sv
module mstat_head #(
  parameter int CAUSE_W = mstat_pkg::CAUSE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld,
  input  logic [CAUSE_W-1:0] ld_cause,
  input  logic               ld_aovf,
  input  logic               ld_trap_en,
  input  logic               cause_ev,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               aovf_set,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               aovf_q,
  output logic               trap_en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= '0;
      aovf_q    <= 1'b0;
      trap_en_q <= 1'b0;
    end else if (ld) begin
      cause_q   <= ld_cause;
      aovf_q    <= ld_aovf;
      trap_en_q <= ld_trap_en;
    end else begin
      if (cause_ev && (cause_q == '0)) cause_q <= cause_in;
      if (aovf_set) aovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/media_status_unit.sv
module media_status_unit #(
  parameter int CAUSE_W  = mstat_pkg::CAUSE_W_DEF,
  parameter int STICKY_W = mstat_pkg::STICKY_W_DEF,
  parameter int WORD_W   = CAUSE_W + STICKY_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                setup_valid,
  input  logic                setup_lane,
  input  logic                setup_keep,
  input  logic                exc_valid,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic                exc_lane,
  input  logic [STICKY_W-1:0] exc_sticky,
  input  logic                alt_mode,
  input  logic                sw_wr_en,
  input  logic                sw_wr_sel,
  input  logic [WORD_W-1:0]   sw_wr_data,
  output logic [WORD_W-1:0]   stat0_word,
  output logic [WORD_W-1:0]   stat1_word,
  output logic                trap_req
);
  localparam int LANES      = 2;
  localparam int OVF_BIT    = CAUSE_W;
  localparam int STICKY_LSB = CAUSE_W + 1;
  localparam int AOVF_BIT   = STICKY_LSB + STICKY_W;
  localparam int TRAPEN_BIT = AOVF_BIT + 1;

  // named internal events
  logic [LANES-1:0]   lane_set, lane_clr, lane_ld;
  logic               aovf_set, trap_fire, ev_ovf;
  logic [CAUSE_W-1:0] cause_q;
  logic               aovf_q, trap_en_q;
  logic [LANES-1:0]   ovf_q;
  logic [STICKY_W-1:0] sticky_q [LANES];

  mstat_steer #(.CAUSE_W(CAUSE_W), .LANES(LANES)) steer_i (
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .exc_lane   (exc_lane),
    .alt_mode   (alt_mode),
    .trap_en    (trap_en_q),
    .setup_valid(setup_valid),
    .setup_lane (setup_lane),
    .setup_keep (setup_keep),
    .lane_set   (lane_set),
    .lane_clr   (lane_clr),
    .aovf_set   (aovf_set),
    .trap_fire  (trap_fire),
    .ev_ovf     (ev_ovf)
  );

  mstat_head #(.CAUSE_W(CAUSE_W)) head_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (lane_ld[0]),
    .ld_cause  (sw_wr_data[CAUSE_W-1:0]),
    .ld_aovf   (sw_wr_data[AOVF_BIT]),
    .ld_trap_en(sw_wr_data[TRAPEN_BIT]),
    .cause_ev  (exc_valid),
    .cause_in  (exc_cause),
    .aovf_set  (aovf_set),
    .cause_q   (cause_q),
    .aovf_q    (aovf_q),
    .trap_en_q (trap_en_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ld[i] = sw_wr_en && (sw_wr_sel == 1'(i));
    mstat_lane #(.STICKY_W(STICKY_W)) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (lane_ld[i]),
      .ld_ovf   (sw_wr_data[OVF_BIT]),
      .ld_sticky(sw_wr_data[STICKY_LSB +: STICKY_W]),
      .set      (lane_set[i]),
      .clr      (lane_clr[i]),
      .sticky_in(exc_sticky),
      .ovf_q    (ovf_q[i]),
      .sticky_q (sticky_q[i])
    );
  end

  always_comb begin
    stat0_word = '0;
    stat0_word[CAUSE_W-1:0]              = cause_q;
    stat0_word[OVF_BIT]                  = ovf_q[0];
    stat0_word[STICKY_LSB +: STICKY_W]   = sticky_q[0];
    stat0_word[AOVF_BIT]                 = aovf_q;
    stat0_word[TRAPEN_BIT]               = trap_en_q;
    stat1_word = '0;
    stat1_word[OVF_BIT]                  = ovf_q[1];
    stat1_word[STICKY_LSB +: STICKY_W]   = sticky_q[1];
  end

  assign trap_req = trap_fire;
endmodule

// File: rtl/mstat_checker.sv
module mstat_checker #(
  parameter int CAUSE_W  = 3,
  parameter int STICKY_W = 4,
  parameter int WORD_W   = CAUSE_W + STICKY_W + 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                setup_valid,
  input logic                setup_lane,
  input logic                setup_keep,
  input logic                exc_valid,
  input logic [CAUSE_W-1:0]  exc_cause,
  input logic                exc_lane,
  input logic                alt_mode,
  input logic                sw_wr_en,
  input logic                sw_wr_sel,
  input logic [WORD_W-1:0]   stat0_word,
  input logic [WORD_W-1:0]   stat1_word,
  input logic                trap_req
);
  localparam int OVF_BIT    = CAUSE_W;
  localparam int STICKY_LSB = CAUSE_W + 1;
  localparam int AOVF_BIT   = STICKY_LSB + STICKY_W;
  localparam int TRAPEN_BIT = AOVF_BIT + 1;

  logic ovf_ev, sw0, sw1, to_l0, to_l1;
  assign ovf_ev = exc_valid && (exc_cause == CAUSE_W'(1));
  assign sw0    = sw_wr_en && !sw_wr_sel;
  assign sw1    = sw_wr_en && sw_wr_sel;
  assign to_l0  = ovf_ev && (alt_mode || !exc_lane);
  assign to_l1  = ovf_ev && !alt_mode && exc_lane;

  p_first_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0_word[CAUSE_W-1:0] != '0 && !sw0) |=> $stable(stat0_word[CAUSE_W-1:0]));

  p_nonovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !ovf_ev && !setup_valid && !sw_wr_en)
      |=> ($stable(stat0_word[WORD_W-1:OVF_BIT]) && $stable(stat1_word)));

  p_lane1_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (to_l1 && !sw1) |=> stat1_word[OVF_BIT]);

  p_lane0_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (to_l0 && !sw0) |=> stat0_word[OVF_BIT]);

  p_aovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !(alt_mode && stat0_word[TRAPEN_BIT]) && !sw0) |=> stat0_word[AOVF_BIT]);

  p_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (ovf_ev && alt_mode && stat0_word[TRAPEN_BIT]));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && !setup_lane && !setup_keep && !to_l0 && !sw0)
      |=> (!stat0_word[OVF_BIT] && stat0_word[STICKY_LSB +: STICKY_W] == '0));

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && setup_lane && setup_keep && !exc_valid && !sw_wr_en)
      |=> $stable(stat1_word));

  p_sec_layout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1_word[CAUSE_W-1:0] == '0 && stat1_word[WORD_W-1:AOVF_BIT] == '0));
endmodule

bind media_status_unit mstat_checker #(
  .CAUSE_W(CAUSE_W), .STICKY_W(STICKY_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_lane(setup_lane),
  .setup_keep(setup_keep), .exc_valid(exc_valid), .exc_cause(exc_cause),
  .exc_lane(exc_lane), .alt_mode(alt_mode), .sw_wr_en(sw_wr_en),
  .sw_wr_sel(sw_wr_sel), .stat0_word(stat0_word), .stat1_word(stat1_word),
  .trap_req(trap_req)
);

// File: tb/media_status_unit_tb.sv
module media_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_valid = 0, setup_lane = 0, setup_keep = 0;
  logic exc_valid = 0, exc_lane = 0, alt_mode = 0;
  logic [2:0] exc_cause = '0;
  logic [3:0] exc_sticky = '0;
  logic sw_wr_en = 0, sw_wr_sel = 0;
  logic [WW-1:0] sw_wr_data = '0;
  logic [WW-1:0] stat0_word, stat1_word;
  logic trap_req;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  media_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_lane(setup_lane),
    .setup_keep(setup_keep), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_lane(exc_lane), .exc_sticky(exc_sticky), .alt_mode(alt_mode),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .stat0_word(stat0_word), .stat1_word(stat1_word), .trap_req(trap_req)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic          sv, sl, sk, ev;
    logic [2:0]    cause;
    logic          el;
    logic [3:0]    stk;
    logic          alt;
    logic [WW-1:0] e0, e1;
    logic          etrap;
  } row_t;

  // word layout: [2:0] cause, [3] ovf, [7:4] sticky, [8] accumulated, [9] trap enable
  localparam int NROWS = 10;
  localparam row_t TBL [NROWS] = '{
    '{4'd3, 1'b0,1'b0,1'b0, 1'b1, 3'd1, 1'b1, 4'h3, 1'b0, 10'h101, 10'h038, 1'b0}, // R3 R5
    '{4'd1, 1'b0,1'b0,1'b0, 1'b1, 3'd3, 1'b0, 4'hF, 1'b0, 10'h101, 10'h038, 1'b0}, // R1 R2
    '{4'd4, 1'b0,1'b0,1'b0, 1'b1, 3'd1, 1'b0, 4'h4, 1'b0, 10'h149, 10'h038, 1'b0}, // R4
    '{4'd8, 1'b1,1'b1,1'b1, 1'b0, 3'd0, 1'b0, 4'h0, 1'b0, 10'h149, 10'h038, 1'b0}, // R8 keep
    '{4'd8, 1'b1,1'b1,1'b0, 1'b0, 3'd0, 1'b0, 4'h0, 1'b0, 10'h149, 10'h000, 1'b0}, // R8 clear
    '{4'd9, 1'b1,1'b0,1'b0, 1'b1, 3'd1, 1'b0, 4'h8, 1'b0, 10'h1C9, 10'h000, 1'b0}, // R9 lane 0
    '{4'd7, 1'b1,1'b0,1'b0, 1'b0, 3'd0, 1'b0, 4'h0, 1'b0, 10'h101, 10'h000, 1'b0}, // R7
    '{4'd4, 1'b0,1'b0,1'b0, 1'b1, 3'd1, 1'b1, 4'h2, 1'b1, 10'h129, 10'h000, 1'b0}, // R4 alternate
    '{4'd9, 1'b1,1'b1,1'b0, 1'b1, 3'd1, 1'b1, 4'h1, 1'b0, 10'h129, 10'h018, 1'b0}, // R9 lane 1
    '{4'd7, 1'b1,1'b0,1'b0, 1'b1, 3'd1, 1'b1, 4'h2, 1'b0, 10'h101, 10'h038, 1'b0}  // R7 other lane busy
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus; trap sampled before the edge, words after it
  task automatic cycle(input logic sv, sl, sk, ev, input logic [2:0] c, input logic el,
                       input logic [3:0] stk, input logic alt, input logic we, ws,
                       input logic [WW-1:0] wd, output logic trap_seen);
    @(negedge clk);
    setup_valid = sv; setup_lane = sl; setup_keep = sk;
    exc_valid = ev; exc_cause = c; exc_lane = el; exc_sticky = stk; alt_mode = alt;
    sw_wr_en = we; sw_wr_sel = ws; sw_wr_data = wd;
    #1 trap_seen = trap_req;
    @(posedge clk);
    #1;
    setup_valid = 0; exc_valid = 0; sw_wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic t;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset primary", 32'(stat0_word), 32'h0);
    check("R11 reset secondary", 32'(stat1_word), 32'h0);
    check("R11 reset trap", 32'(trap_req), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      cycle(TBL[i].sv, TBL[i].sl, TBL[i].sk, TBL[i].ev, TBL[i].cause, TBL[i].el,
            TBL[i].stk, TBL[i].alt, 1'b0, 1'b0, '0, t);
      check($sformatf("R%0d row %0d trap", TBL[i].req, i), 32'(t), 32'(TBL[i].etrap));
      check($sformatf("R%0d row %0d primary", TBL[i].req, i), 32'(stat0_word), 32'(TBL[i].e0));
      check($sformatf("R%0d row %0d secondary", TBL[i].req, i), 32'(stat1_word), 32'(TBL[i].e1));
    end

    // R10 load primary with only the trap-enable bit
    cycle(0,0,0, 0,3'd0,0,4'h0, 0, 1,0, 10'h200, t);
    check("R10 load primary", 32'(stat0_word), 32'h200);
    check("R10 secondary untouched", 32'(stat1_word), 32'h038);

    // R6 immediate request; R5 accumulated flag withheld
    cycle(0,0,0, 1,3'd1,1,4'h5, 1, 0,0, '0, t);
    check("R6 trap in alternate mode", 32'(t), 32'h1);
    check("R5 no accumulate when trapping", 32'(stat0_word), 32'h259);
    check("R4 alternate lane1 to primary", 32'(stat1_word), 32'h038);

    // R6 default mode with trap enable: no request, R5 accumulate
    cycle(0,0,0, 1,3'd1,0,4'h0, 0, 0,0, '0, t);
    check("R6 no trap in default mode", 32'(t), 32'h0);
    check("R5 accumulate in default mode", 32'(stat0_word), 32'h359);

    // R10 secondary stores only flag and sticky bits
    cycle(0,0,0, 0,3'd0,0,4'h0, 0, 1,1, 10'h3FF, t);
    check("R10 secondary layout", 32'(stat1_word), 32'h0F8);

    // R10 load beats a same-cycle overflow
    cycle(0,0,0, 1,3'd1,0,4'hF, 0, 1,0, 10'h007, t);
    check("R10 load priority", 32'(stat0_word), 32'h007);
    check("R10 load priority trap", 32'(t), 32'h0);

    // R11 reset in mid run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R11 mid-run reset primary", 32'(stat0_word), 32'h0);
    check("R11 mid-run reset secondary", 32'(stat1_word), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R5 alternate mode without trap enable accumulates
    cycle(0,0,0, 1,3'd1,1,4'h1, 1, 0,0, '0, t);
    check("R6 no trap without enable", 32'(t), 32'h0);
    check("R5 alternate accumulate", 32'(stat0_word), 32'h119);
    check("R4 alternate secondary clean", 32'(stat1_word), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule